// File: doc/BRIEF.md
# Supply Monitor Reset and Warning Controller

This block is the digital side of a supply monitor. Three comparator outputs arrive as digital levels: one says the supply is below the power-on rearm level, one says it is below the detect threshold, and one says it is below the warning threshold. The block passes them through a two-flop synchronizer. It then drives the system reset and a sticky two-bit reset-cause register. It also keeps a warning flag with a maskable interrupt request, and it picks between a deep and a shallow low-power stop mode when a stop request arrives.

Software uses a 5-bit control register with the following fields:

| Bit | Field | Meaning |
|---|---|---|
| 0 | detector enable | turns the detector on |
| 1 | reset enable | lets a low-voltage event cause a reset |
| 2 | stop enable | keeps the detector on during stop |
| 3 | warning interrupt enable | passes the warning flag to the interrupt request |
| 4 | acknowledge | write-only; writing 1 asks to clear the warning flag |

The reset sequencer has four states:

- `RS_POR_HOLD`: the rearm comparator is asserted.
- `RS_SUPPLY_WAIT`: the rearm comparator has released, and the block waits for the detect comparator to release.
- `RS_RUN`: the system is out of reset.
- `RS_LV_HOLD`: a low-voltage reset is in progress.

The sequencer takes these transitions:

- From any state to `RS_POR_HOLD` when the rearm comparator is asserted.
- From `RS_POR_HOLD` to `RS_SUPPLY_WAIT` when rearm releases.
- From `RS_SUPPLY_WAIT` to `RS_RUN` when detect releases.
- From `RS_RUN` to `RS_LV_HOLD` when detect is asserted while the low-voltage reset is armed.
- From `RS_LV_HOLD` to `RS_RUN` when detect releases.

The power-mode machine has three states: `PM_RUN`, `PM_DEEP` and `PM_SHALLOW`. It takes these transitions:

- From `PM_RUN` to `PM_DEEP` or `PM_SHALLOW` when a stop is requested.
- From either stop state back to `PM_RUN` when the request drops.
- From any state to `PM_RUN` while the system reset is asserted.

Top module: `lvd_reset_ctrl`

## Requirements
- R1: While the synchronized rearm input is high, `sys_rst_o` is 1. After rearm releases, `sys_rst_o` stays 1 until the synchronized detect input is low.
- R2: A power-on reset sets `status_o` to 2'b11. Bit 0 is the power-on cause and bit 1 is the low-voltage cause. Both bits hold until the next reset.
- R3: A low-voltage reset starts only when control bit 0 (detector enable) and bit 1 (reset enable) are both 1, and the detector is active.
- R4: A low-voltage reset clears `status_o` on entry. It holds `sys_rst_o` until detect is low, then sets `status_o` bit 1, which gives 2'b10.
- R5: The warning flag sets when the synchronized warning input is high while the detector is active. `warn_irq_o` is high only while both the flag and control bit 3 are 1.
- R6: Writing 1 to control bit 4 (acknowledge) clears the flag only if the synchronized warning input is low. Otherwise the flag stays set.
- R7: In deep stop the detector is inactive (`det_active_o` is 0) and detect causes no reset. In shallow stop the detector stays active.
- R8: A stop request taken in `PM_RUN` selects shallow stop if control bits 0 and 2 are both 1, and deep stop otherwise. The mode is fixed at entry and ends when the request drops.
- R9: `ctrl_rd_o` bit 4 always reads 0. The control register resets to 5'h03, returns to 5'h03 during any system reset, and ignores writes while the system reset is asserted.
- R10: A comparator change takes effect on the third rising edge: two synchronizer flops, then the state register.
- R11: The warning flag is cleared while the system reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous initialisation of the digital flops, active low |
| cmp_rearm_i | input | 1 | Supply below power-on rearm level |
| cmp_detect_i | input | 1 | Supply below detect threshold |
| cmp_warn_i | input | 1 | Supply below warning threshold |
| stop_req_i | input | 1 | Low-power stop request level |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 5 | Control write data |
| ctrl_rd_o | output | 5 | Control readback; bit 4 reads 0 |
| status_o | output | 2 | Sticky reset cause |
| sys_rst_o | output | 1 | System reset, active high |
| warn_flag_o | output | 1 | Warning flag |
| warn_irq_o | output | 1 | Warning interrupt request |
| stop_deep_o | output | 1 | Deep stop selected |
| stop_shallow_o | output | 1 | Shallow stop selected |
| det_active_o | output | 1 | Detector currently active |

## Verification
The reset sequencer is driven through a power-on ramp with detect still low, then a slow release of detect. It is also driven through detect dips with the reset enable off and then on. These runs separate the power-on cause from the low-voltage cause and expose the three-edge latency. The warning flag gets acknowledge writes both while the warning input is high and after it has dropped, which separates a conditional clear from a plain one. It is also tried with the detector off. Stop requests are given under both enable settings, with a detect dip during each mode and a control write during deep stop. These runs show whether the mode is latched at entry and whether the detector really sleeps in deep stop.

// File: rtl/lvd_pkg.sv
`timescale 1ns/1ps
package lvd_pkg;
    localparam int CMP_N      = 3;
    localparam int IDX_REARM  = 0;
    localparam int IDX_DETECT = 1;
    localparam int IDX_WARN   = 2;
    localparam int CTRL_W     = 5;
    localparam int ACK_BIT    = CTRL_W - 1;
    localparam int STAT_W     = 2;
    localparam logic [STAT_W-1:0] STAT_POR = 2'b01;
    localparam logic [STAT_W-1:0] STAT_LV  = 2'b10;

    typedef enum logic [1:0] {
        RS_POR_HOLD    = 2'd0,
        RS_SUPPLY_WAIT = 2'd1,
        RS_RUN         = 2'd2,
        RS_LV_HOLD     = 2'd3
    } rst_state_e;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_DEEP    = 2'd1,
        PM_SHALLOW = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic warn_ie;
        logic stop_en;
        logic rst_en;
        logic det_en;
    } ctrl_t;

    localparam ctrl_t CTRL_DEF = '{warn_ie: 1'b0, stop_en: 1'b0, rst_en: 1'b1, det_en: 1'b1};
endpackage

// File: rtl/lvd_sync.sv
`timescale 1ns/1ps
module lvd_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lvd_ctrl_reg.sv
`timescale 1ns/1ps
module lvd_ctrl_reg
    import lvd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              ack,
    output logic [CTRL_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl <= CTRL_DEF;
        else if (hold)   ctrl <= CTRL_DEF;
        else if (wr_en)  ctrl <= ctrl_t'(wr_data[CTRL_W-2:0]);
    end

    // acknowledge is a strobe only; it is never stored
    assign ack     = wr_en && !hold && wr_data[ACK_BIT];
    assign rd_data = {1'b0, ctrl};
endmodule

// File: rtl/lvd_rst_fsm.sv
`timescale 1ns/1ps
module lvd_rst_fsm
    import lvd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              below_rearm,
    input  logic              below_detect,
    input  logic              lv_armed,
    output logic              sys_rst,
    output logic [STAT_W-1:0] status
);
    rst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_POR_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (below_rearm) begin
            state_d = RS_POR_HOLD;
        end else begin
            unique case (state_q)
                RS_POR_HOLD:    state_d = RS_SUPPLY_WAIT;
                RS_SUPPLY_WAIT: if (!below_detect) state_d = RS_RUN;
                RS_RUN:         if (lv_armed && below_detect) state_d = RS_LV_HOLD;
                RS_LV_HOLD:     if (!below_detect) state_d = RS_RUN;
                default:        state_d = RS_POR_HOLD;
            endcase
        end
    end

    always_comb begin
        sys_rst = (state_q != RS_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status <= STAT_POR | STAT_LV;
        else if (state_d == RS_POR_HOLD && state_q != RS_POR_HOLD)
            status <= STAT_POR | STAT_LV;
        else if (state_q == RS_RUN && state_d == RS_LV_HOLD)
            status <= '0;
        else if (state_q == RS_LV_HOLD && state_d == RS_RUN)
            status <= status | STAT_LV;
    end
endmodule

// File: rtl/lvd_pwr_fsm.sv
`timescale 1ns/1ps
module lvd_pwr_fsm
    import lvd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic stop_req,
    input  logic det_en,
    input  logic stop_en,
    output logic deep,
    output logic shallow
);
    pwr_state_e pm_q, pm_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pm_q <= PM_RUN;
        else        pm_q <= pm_d;
    end

    always_comb begin
        pm_d = pm_q;
        if (hold) begin
            pm_d = PM_RUN;
        end else begin
            unique case (pm_q)
                PM_RUN:     if (stop_req) pm_d = (det_en && stop_en) ? PM_SHALLOW : PM_DEEP;
                PM_DEEP:    if (!stop_req) pm_d = PM_RUN;
                PM_SHALLOW: if (!stop_req) pm_d = PM_RUN;
                default:    pm_d = PM_RUN;
            endcase
        end
    end

    always_comb begin
        deep    = (pm_q == PM_DEEP);
        shallow = (pm_q == PM_SHALLOW);
    end
endmodule

// File: rtl/lvd_warn.sv
`timescale 1ns/1ps
module lvd_warn (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic below_warn,
    input  logic active,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   flag <= 1'b0;
        else if (hold)                flag <= 1'b0;
        else if (below_warn && active) flag <= 1'b1;
        else if (ack && !below_warn)  flag <= 1'b0;
    end
endmodule

// File: rtl/lvd_reset_ctrl.sv
`timescale 1ns/1ps
module lvd_reset_ctrl
    import lvd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_rearm_i,
    input  logic              cmp_detect_i,
    input  logic              cmp_warn_i,
    input  logic              stop_req_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] ctrl_rd_o,
    output logic [STAT_W-1:0] status_o,
    output logic              sys_rst_o,
    output logic              warn_flag_o,
    output logic              warn_irq_o,
    output logic              stop_deep_o,
    output logic              stop_shallow_o,
    output logic              det_active_o
);
    localparam logic [CMP_N-1:0] SYNC_RST = (CMP_N'(1) << IDX_REARM) | (CMP_N'(1) << IDX_DETECT);

    logic [CMP_N-1:0] cmp_raw, cmp_s;
    ctrl_t ctrl;
    logic  ack, det_active, lv_armed;

    assign cmp_raw[IDX_REARM]  = cmp_rearm_i;
    assign cmp_raw[IDX_DETECT] = cmp_detect_i;
    assign cmp_raw[IDX_WARN]   = cmp_warn_i;

    lvd_sync #(.W(CMP_N), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(cmp_s)
    );

    lvd_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .hold(sys_rst_o), .wr_en(wr_en_i), .wr_data(wr_data_i),
        .ctrl(ctrl), .ack(ack), .rd_data(ctrl_rd_o)
    );

    lvd_pwr_fsm u_pwr (
        .clk(clk), .rst_n(rst_n), .hold(sys_rst_o), .stop_req(stop_req_i),
        .det_en(ctrl.det_en), .stop_en(ctrl.stop_en),
        .deep(stop_deep_o), .shallow(stop_shallow_o)
    );

    // detector sleeps only in deep stop
    assign det_active = ctrl.det_en && !stop_deep_o;
    assign lv_armed   = det_active && ctrl.rst_en;

    lvd_rst_fsm u_rst (
        .clk(clk), .rst_n(rst_n), .below_rearm(cmp_s[IDX_REARM]), .below_detect(cmp_s[IDX_DETECT]),
        .lv_armed(lv_armed), .sys_rst(sys_rst_o), .status(status_o)
    );

    lvd_warn u_warn (
        .clk(clk), .rst_n(rst_n), .hold(sys_rst_o), .below_warn(cmp_s[IDX_WARN]),
        .active(det_active), .ack(ack), .flag(warn_flag_o)
    );

    assign warn_irq_o   = warn_flag_o && ctrl.warn_ie;
    assign det_active_o = det_active;
endmodule

// File: rtl/lvd_reset_ctrl_chk.sv
`timescale 1ns/1ps
module lvd_reset_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rearm_s,
    input logic       detect_s,
    input logic       warn_s,
    input logic       sys_rst_o,
    input logic [1:0] status_o,
    input logic       warn_flag_o,
    input logic       det_active_o,
    input logic       stop_shallow_o,
    input logic [4:0] ctrl_rd_o
);
    // R1
    rearm_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_s |=> sys_rst_o);
    // R2
    por_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_s |=> (status_o == 2'b11));
    // R4
    release_after_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> !$past(detect_s));
    // R5
    warn_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_s && det_active_o && !sys_rst_o) |=> warn_flag_o);
    // R6
    warn_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_flag_o && warn_s && !sys_rst_o) |=> warn_flag_o);
    // R8
    shallow_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_shallow_o) |-> $past(ctrl_rd_o[0] && ctrl_rd_o[2]));
endmodule

bind lvd_reset_ctrl lvd_reset_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .rearm_s(cmp_s[0]), .detect_s(cmp_s[1]), .warn_s(cmp_s[2]),
    .sys_rst_o(sys_rst_o), .status_o(status_o), .warn_flag_o(warn_flag_o),
    .det_active_o(det_active_o), .stop_shallow_o(stop_shallow_o), .ctrl_rd_o(ctrl_rd_o)
);

// File: tb/sim_lvd_reset_ctrl.sv
`timescale 1ns/1ps
module sim_lvd_reset_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rearm = 1'b1, detect = 1'b1, warn = 1'b0, stop = 1'b0, wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] ctrl_rd;
    logic [1:0] status;
    logic sys_rst, flag, irq, deep, shallow, det_act;
    int checks = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;

    lvd_reset_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmp_rearm_i(rearm), .cmp_detect_i(detect), .cmp_warn_i(warn),
        .stop_req_i(stop), .wr_en_i(wr_en), .wr_data_i(wr_data), .ctrl_rd_o(ctrl_rd),
        .status_o(status), .sys_rst_o(sys_rst), .warn_flag_o(flag), .warn_irq_o(irq),
        .stop_deep_o(deep), .stop_shallow_o(shallow), .det_active_o(det_act)
    );

    // behavioural reference: reset phase 0 rearm-hold, 1 wait, 2 run, 3 low-voltage hold
    // power mode 0 run, 1 deep, 2 shallow
    logic [2:0] m_s1, m_s2;
    int         m_rs, m_pm;
    logic [3:0] m_ctrl;
    logic       m_flag;
    logic [1:0] m_stat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 3'b011; m_s2 = 3'b011; m_rs = 0; m_pm = 0;
            m_ctrl = 4'h3; m_flag = 1'b0; m_stat = 2'b11;
        end else begin
            bit in_rst, act;
            int n_rs;
            in_rst = (m_rs != 2);
            act = m_ctrl[0] && (m_pm != 1);
            if (m_s2[0]) n_rs = 0;
            else if (m_rs == 0) n_rs = 1;
            else if (m_rs == 1) n_rs = m_s2[1] ? 1 : 2;
            else if (m_rs == 2) n_rs = (act && m_ctrl[1] && m_s2[1]) ? 3 : 2;
            else n_rs = m_s2[1] ? 3 : 2;
            if (n_rs == 0 && m_rs != 0) m_stat = 2'b11;
            else if (m_rs == 2 && n_rs == 3) m_stat = 2'b00;
            else if (m_rs == 3 && n_rs == 2) m_stat = m_stat | 2'b10;
            if (in_rst) m_flag = 1'b0;
            else if (m_s2[2] && act) m_flag = 1'b1;
            else if (wr_en && wr_data[4] && !m_s2[2]) m_flag = 1'b0;
            if (in_rst) m_pm = 0;
            else if (m_pm == 0 && stop) m_pm = (m_ctrl[0] && m_ctrl[2]) ? 2 : 1;
            else if (m_pm != 0 && !stop) m_pm = 0;
            if (in_rst) m_ctrl = 4'h3;
            else if (wr_en) m_ctrl = wr_data[3:0];
            m_rs = n_rs;
            m_s2 = m_s1;
            m_s1 = {warn, detect, rearm};
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 R3 R4 R10 sys_rst", 8'(sys_rst), 8'(m_rs != 2));
            chk("R2 R4 status", 8'(status), 8'(m_stat));
            chk("R5 R6 R11 flag", 8'(flag), 8'(m_flag));
            chk("R5 irq", 8'(irq), 8'(m_flag && m_ctrl[3]));
            chk("R9 ctrl_rd", 8'(ctrl_rd), 8'({1'b0, m_ctrl}));
            chk("R8 deep", 8'(deep), 8'(m_pm == 1));
            chk("R8 shallow", 8'(shallow), 8'(m_pm == 2));
            chk("R7 det_active", 8'(det_act), 8'(m_ctrl[0] && m_pm != 1));
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected below 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        step(3); rst_n = 1'b1;
        step(4);
        chk("R2 power-on status", 8'(status), 8'h3);
        chk("R1 reset during rearm", 8'(sys_rst), 8'h1);
        rearm = 1'b0; step(6);
        chk("R1 held while detect below", 8'(sys_rst), 8'h1);
        detect = 1'b0; step(2);
        chk("R10 not yet after two edges", 8'(sys_rst), 8'h1);
        step(1);
        chk("R10 released on third edge", 8'(sys_rst), 8'h0);
        chk("R2 sticky cause", 8'(status), 8'h3);
        chk("R9 control default", 8'(ctrl_rd), 8'h03);

        wr(5'h01); detect = 1'b1; step(6);
        chk("R3 no reset without reset enable", 8'(sys_rst), 8'h0);
        detect = 1'b0; step(4);

        wr(5'h03); detect = 1'b1; step(3);
        chk("R3 low-voltage reset taken", 8'(sys_rst), 8'h1);
        chk("R4 cause cleared on entry", 8'(status), 8'h0);
        step(3); detect = 1'b0; step(3);
        chk("R4 released after detect", 8'(sys_rst), 8'h0);
        chk("R4 low-voltage cause", 8'(status), 8'h2);

        wr(5'h09); warn = 1'b1; step(3);
        chk("R5 flag set", 8'(flag), 8'h1);
        chk("R5 irq enabled", 8'(irq), 8'h1);
        wr(5'h19);
        chk("R6 ack ignored while below", 8'(flag), 8'h1);
        chk("R9 ack reads zero", 8'(ctrl_rd), 8'h09);
        warn = 1'b0; step(3);
        chk("R6 flag sticky", 8'(flag), 8'h1);
        wr(5'h19);
        chk("R6 ack clears", 8'(flag), 8'h0);
        wr(5'h01); warn = 1'b1; step(3);
        chk("R5 irq masked", 8'(irq), 8'h0);
        warn = 1'b0; step(3); wr(5'h11);
        wr(5'h08); warn = 1'b1; step(4);
        chk("R5 no flag with detector off", 8'(flag), 8'h0);
        warn = 1'b0; step(3);

        wr(5'h03); stop = 1'b1; step(1);
        chk("R8 deep stop", 8'(deep), 8'h1);
        chk("R7 detector off in deep", 8'(det_act), 8'h0);
        detect = 1'b1; wr(5'h07); step(4);
        chk("R7 no reset in deep stop", 8'(sys_rst), 8'h0);
        chk("R8 mode latched at entry", 8'(deep), 8'h1);
        detect = 1'b0; step(3); stop = 1'b0; step(1);
        chk("R8 exit on release", 8'(deep), 8'h0);
        stop = 1'b1; step(1);
        chk("R8 shallow stop", 8'(shallow), 8'h1);
        chk("R7 detector on in shallow", 8'(det_act), 8'h1);
        detect = 1'b1; step(3);
        chk("R7 reset from shallow stop", 8'(sys_rst), 8'h1);
        stop = 1'b0; detect = 1'b0; step(4);
        chk("R4 recovered", 8'(sys_rst), 8'h0);
        chk("R9 control restored by reset", 8'(ctrl_rd), 8'h03);

        wr(5'h09); warn = 1'b1; step(3);
        chk("R5 flag before reset", 8'(flag), 8'h1);
        rearm = 1'b1; step(4);
        chk("R11 flag cleared in reset", 8'(flag), 8'h0);
        wr(5'h1C);
        chk("R9 write ignored in reset", 8'(ctrl_rd), 8'h03);
        rearm = 1'b0; warn = 1'b0; step(3);
        chk("R2 power-on cause again", 8'(status), 8'h3);
        step(3);
        chk("R1 out of reset", 8'(sys_rst), 8'h0);

        step(2);
        summary();
        $finish;
    end
endmodule